// File: doc/BRIEF.md
# External Memory Bus Controller

This controller converts single read and write requests from inside the chip into the strobe sequence of an asynchronous external memory bus. The internal 32-bit address is split into regions. Below 0x20000000 lies a boot PROM region with two chip selects. A memory-mapped I/O region sits at 0x2xxxxxxx, and a group of SRAM banks sits at 0x4xxxxxxx. Each SRAM bank has its own chip select and its own read enable.

An access is accepted only while the controller is idle. Every access starts with one address-setup cycle. This is followed by a programmable number of wait states, and the count is chosen per region. I/O accesses then also wait for an active-low ready input. When the access ends, the strobes are released and a single-cycle response carries the read data. Any address that falls outside every region is answered on the next cycle with an error flag, and the bus is not touched.

The external address keeps its last value while the bus is idle. The data bus and the check-bit bus are driven only during writes. The check bits come from a configuration value and are driven only when the target region is marked as protected. The PROM region can be configured as 8 bits wide, and it then uses only data lane 31:24.

Top module: `extmem_ctrl`

## Requirements
- R1: While `rst` is high and after it is released, all active-low selects and strobes are high, `mem_read` is 0, the data and check-bit buses are high-impedance, `mem_addr` is 0 and `req_ready` is 1.
- R2: Address decoding works as follows. Addresses with bits 31:29 = 000 go to the PROM region: `prom_cs_n[0]` is low when bit 28 = 0 and `prom_cs_n[1]` is low when bit 28 = 1. Bits 31:28 = 0x2 go to the I/O region (`io_cs_n`). Bits 31:28 = 0x4 go to RAM bank `addr[BANK_LSB+2:BANK_LSB]`, and `ram_cs_n[bank]` is low. At most one select is low at any time.
- R3: An accepted access keeps its select and strobes asserted for 2 + N cycles, where N is the region's wait-state count (0 to 15). `req_ready` is 0 during those cycles and `mem_addr` holds `req_addr[27:0]`. In the cycle after the strobes drop, `rsp_valid` is 1 for exactly one cycle with `rsp_err` = 0.
- R4: An I/O access does not end before its 2 + N cycles have passed. After that, it ends on the first rising edge at which `io_rdy_n` is sampled low. A low `io_rdy_n` seen earlier has no effect.
- R5: During a read, `mem_oe_n` is low and `mem_read` is 1, and for a RAM read `ram_oe_n[bank]` is also low. `rsp_rdata` returns the value on `mem_data` sampled at the final edge of the access.
- R6: During a write, `mem_we_n` is low and `ram_wen_n` = ~`req_be`, where bit 0 is the lane for data bits 31:24 and bit 3 is the lane for bits 7:0. `mem_data` carries `req_wdata` only during write cycles and is high-impedance otherwise.
- R7: When `cfg_prom_narrow` = 1, a PROM write drives `req_wdata[7:0]` on `mem_data[31:24]` with `ram_wen_n` = 4'b1110. A PROM read returns {24'h0, `mem_data[31:24]`}.
- R8: `mem_cb` is driven only during writes to a protected region (`cfg_prom_prot` or `cfg_ram_prot`; I/O is never protected). Bit 7 takes the value of `cfg_cb_top` and bits 6:0 take the value of `cfg_cb_low`. At all other times `mem_cb` is high-impedance.
- R9: While no access is in progress, `mem_addr` keeps the address of the most recent completed access.
- R10: An address outside every region, including RAM bank numbers of `RAM_BANKS` or higher, gives `rsp_valid` = 1 with `rsp_err` = 1 on the next cycle. No strobe is asserted and `mem_addr` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is 1 |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Internal byte address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables, bit 0 = lane 31:24 |
| req_ready | output | 1 | Controller is idle |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion was an unmapped address |
| rsp_rdata | output | 32 | Read data |
| cfg_prom_ws | input | 4 | PROM wait states |
| cfg_ram_ws | input | 4 | RAM wait states |
| cfg_io_ws | input | 4 | I/O wait states |
| cfg_prom_narrow | input | 1 | PROM region is 8 bits wide |
| cfg_prom_prot | input | 1 | PROM region is protected |
| cfg_ram_prot | input | 1 | RAM region is protected |
| cfg_cb_top | input | 1 | Value for check-bit bus bit 7 |
| cfg_cb_low | input | 7 | Value for check-bit bus bits 6:0 |
| mem_addr | output | 28 | External address |
| mem_data | inout | 32 | External data bus |
| mem_cb | inout | 8 | External check-bit bus |
| mem_oe_n | output | 1 | Read output enable, active low |
| mem_read | output | 1 | Read cycle indicator, active high |
| mem_we_n | output | 1 | Write strobe, active low |
| prom_cs_n | output | 2 | PROM selects for low and high half |
| ram_cs_n | output | RAM_BANKS | RAM bank selects |
| ram_oe_n | output | RAM_BANKS | RAM bank output enables |
| ram_wen_n | output | 4 | Byte-lane write enables |
| io_cs_n | output | 1 | I/O region select |
| io_rdy_n | input | 1 | I/O ready, active low |

## Verification
The assertions assume that the configuration inputs do not change while an access is in progress. They also assume that the external side never drives `mem_data` except while `mem_oe_n` is low, and that `io_rdy_n` is only used while `io_cs_n` is low. The stimulus follows these rules: it changes wait-state and width settings only between accesses, its memory model answers only on asserted read enables, and it raises `io_rdy_n` again as soon as an I/O access ends. Requests are issued one at a time from the idle state, so `req_valid` is never presented while the controller is busy.

// File: rtl/extmem_pkg.sv
package extmem_pkg;
  localparam int BANK_IDX_W = 3;
  localparam int WS_W       = 4;

  typedef enum logic [1:0] {
    AR_NONE = 2'd0,
    AR_PROM = 2'd1,
    AR_RAM  = 2'd2,
    AR_IO   = 2'd3
  } area_e;

  typedef struct packed {
    area_e                 area;
    logic                  prom_hi;
    logic [BANK_IDX_W-1:0] bank;
    logic [WS_W-1:0]       ws;
    logic                  narrow;
    logic                  prot;
  } route_t;
endpackage

// File: rtl/extmem_decode.sv
module extmem_decode
  import extmem_pkg::*;
#(
  parameter int RAM_BANKS = 5,
  parameter int BANK_LSB  = 20
) (
  input  logic [31:0]     addr,
  input  logic [WS_W-1:0] prom_ws,
  input  logic [WS_W-1:0] ram_ws,
  input  logic [WS_W-1:0] io_ws,
  input  logic            prom_narrow,
  input  logic            prom_prot,
  input  logic            ram_prot,
  output route_t          route
);
  logic [BANK_IDX_W-1:0] bank_field;
  assign bank_field = addr[BANK_LSB +: BANK_IDX_W];

  always_comb begin
    route      = '0;
    route.area = AR_NONE;
    if (addr[31:29] == 3'b000) begin
      route.area    = AR_PROM;
      route.prom_hi = addr[28];
      route.ws      = prom_ws;
      route.narrow  = prom_narrow;
      route.prot    = prom_prot;
    end else if (addr[31:28] == 4'h2) begin
      route.area = AR_IO;
      route.ws   = io_ws;
    end else if (addr[31:28] == 4'h4 && int'(bank_field) < RAM_BANKS) begin
      route.area = AR_RAM;
      route.bank = bank_field;
      route.ws   = ram_ws;
      route.prot = ram_prot;
    end
  end
endmodule

// File: rtl/extmem_seq.sv
module extmem_seq
  import extmem_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            is_io,
  input  logic [WS_W-1:0] ws,
  input  logic            rdy_n,
  output logic            idle,
  output logic            done
);
  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_WAIT} st_e;
  st_e             st;
  logic [WS_W-1:0] cnt;
  logic            io_q;

  assign idle = (st == S_IDLE);
  assign done = (st == S_WAIT) && (cnt == '0) && (!io_q || !rdy_n);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_IDLE;
      cnt  <= '0;
      io_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st   <= S_SETUP;
          cnt  <= ws;
          io_q <= is_io;
        end
        S_SETUP: st <= S_WAIT;
        S_WAIT: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (done) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R4
  io_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_WAIT && cnt == '0 && io_q && rdy_n) |=> (st == S_WAIT));
  // R3
  setup_len_chk: assert property (@(posedge clk) disable iff (rst)
    (st == S_SETUP) |=> (st == S_WAIT));
endmodule

// File: rtl/extmem_ctrl.sv
module extmem_ctrl
  import extmem_pkg::*;
#(
  parameter int RAM_BANKS = 5,
  parameter int BANK_LSB  = 20
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [31:0]          req_addr,
  input  logic [31:0]          req_wdata,
  input  logic [3:0]           req_be,
  output logic                 req_ready,
  output logic                 rsp_valid,
  output logic                 rsp_err,
  output logic [31:0]          rsp_rdata,
  input  logic [3:0]           cfg_prom_ws,
  input  logic [3:0]           cfg_ram_ws,
  input  logic [3:0]           cfg_io_ws,
  input  logic                 cfg_prom_narrow,
  input  logic                 cfg_prom_prot,
  input  logic                 cfg_ram_prot,
  input  logic                 cfg_cb_top,
  input  logic [6:0]           cfg_cb_low,
  output logic [27:0]          mem_addr,
  inout  wire  [31:0]          mem_data,
  inout  wire  [7:0]           mem_cb,
  output logic                 mem_oe_n,
  output logic                 mem_read,
  output logic                 mem_we_n,
  output logic [1:0]           prom_cs_n,
  output logic [RAM_BANKS-1:0] ram_cs_n,
  output logic [RAM_BANKS-1:0] ram_oe_n,
  output logic [3:0]           ram_wen_n,
  output logic                 io_cs_n,
  input  logic                 io_rdy_n
);
  route_t route;
  logic   idle, done, accept, start;
  logic   narrow_q, drv_q, cb_drv_q;
  logic [31:0] dout_q;
  logic [7:0]  cb_q;
  logic [RAM_BANKS-1:0] bank_sel_n;

  extmem_decode #(.RAM_BANKS(RAM_BANKS), .BANK_LSB(BANK_LSB)) u_dec (
    .addr(req_addr), .prom_ws(cfg_prom_ws), .ram_ws(cfg_ram_ws), .io_ws(cfg_io_ws),
    .prom_narrow(cfg_prom_narrow), .prom_prot(cfg_prom_prot), .ram_prot(cfg_ram_prot),
    .route(route)
  );

  assign accept = req_valid && idle;
  assign start  = accept && (route.area != AR_NONE);

  extmem_seq u_seq (
    .clk(clk), .rst(rst), .start(start), .is_io(route.area == AR_IO),
    .ws(route.ws), .rdy_n(io_rdy_n), .idle(idle), .done(done)
  );

  assign req_ready = idle;

  generate
    for (genvar b = 0; b < RAM_BANKS; b++) begin : g_bank
      assign bank_sel_n[b] = !(route.area == AR_RAM && route.bank == BANK_IDX_W'(b));
    end
  endgenerate

  assign mem_data = drv_q    ? dout_q : 'z;
  assign mem_cb   = cb_drv_q ? cb_q   : 'z;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
      mem_addr  <= '0;
      mem_oe_n  <= 1'b1;
      mem_read  <= 1'b0;
      mem_we_n  <= 1'b1;
      prom_cs_n <= 2'b11;
      ram_cs_n  <= '1;
      ram_oe_n  <= '1;
      ram_wen_n <= 4'hf;
      io_cs_n   <= 1'b1;
      narrow_q  <= 1'b0;
      drv_q     <= 1'b0;
      dout_q    <= '0;
      cb_drv_q  <= 1'b0;
      cb_q      <= '0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      if (accept && route.area == AR_NONE) begin
        rsp_valid <= 1'b1;
        rsp_err   <= 1'b1;
        rsp_rdata <= '0;
      end else if (start) begin
        mem_addr  <= req_addr[27:0];
        narrow_q  <= route.narrow;
        prom_cs_n <= (route.area != AR_PROM) ? 2'b11 : (route.prom_hi ? 2'b01 : 2'b10);
        ram_cs_n  <= bank_sel_n;
        ram_oe_n  <= req_write ? '1 : bank_sel_n;
        io_cs_n   <= (route.area != AR_IO);
        mem_oe_n  <= req_write;
        mem_read  <= !req_write;
        mem_we_n  <= !req_write;
        ram_wen_n <= !req_write ? 4'hf : (route.narrow ? 4'b1110 : ~req_be);
        drv_q     <= req_write;
        dout_q    <= route.narrow ? {req_wdata[7:0], 24'h0} : req_wdata;
        cb_drv_q  <= req_write && route.prot;
        cb_q      <= {cfg_cb_top, cfg_cb_low};
      end else if (done) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= narrow_q ? {24'h0, mem_data[31:24]} : mem_data;
        prom_cs_n <= 2'b11;
        ram_cs_n  <= '1;
        ram_oe_n  <= '1;
        io_cs_n   <= 1'b1;
        mem_oe_n  <= 1'b1;
        mem_read  <= 1'b0;
        mem_we_n  <= 1'b1;
        ram_wen_n <= 4'hf;
        drv_q     <= 1'b0;
        cb_drv_q  <= 1'b0;
      end
    end
  end

  // R2
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({~prom_cs_n, ~ram_cs_n, ~io_cs_n}) <= 1);
  // R3
  addr_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (!req_ready && $past(!req_ready)) |-> $stable(mem_addr));
  // R4
  io_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_err && $past(!io_cs_n)) |-> $past(!io_rdy_n));
  // R5
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (mem_we_n && mem_read && ram_wen_n == 4'hf));
  // R10
  err_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> ($stable(mem_addr) && io_cs_n && prom_cs_n == 2'b11 && mem_we_n));
endmodule

// File: tb/tb_extmem_ctrl.sv
module tb_extmem_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NBANK = 5;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [3:0]  req_be = 4'hf;
  logic req_ready, rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic [3:0] cfg_prom_ws = 4'd1, cfg_ram_ws = 4'd0, cfg_io_ws = 4'd2;
  logic cfg_prom_narrow = 1'b0, cfg_prom_prot = 1'b0, cfg_ram_prot = 1'b1;
  logic cfg_cb_top = 1'b1;
  logic [6:0] cfg_cb_low = 7'h2b;
  logic [27:0] mem_addr;
  wire  [31:0] mem_data;
  wire  [7:0]  mem_cb;
  logic mem_oe_n, mem_read, mem_we_n, io_cs_n;
  logic io_rdy_n = 1'b1;
  logic [1:0] prom_cs_n;
  logic [NBANK-1:0] ram_cs_n, ram_oe_n;
  logic [3:0] ram_wen_n;

  int checks = 0, bad = 0;
  logic [27:0] addr_hold = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] pat(input logic [27:0] a);
    return {a[15:0], ~a[15:0]} ^ 32'h3c5a_0f96;
  endfunction

  assign mem_data = !mem_oe_n ? pat(mem_addr) : 'z;

  extmem_ctrl #(.RAM_BANKS(NBANK), .BANK_LSB(20)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .cfg_prom_ws(cfg_prom_ws), .cfg_ram_ws(cfg_ram_ws), .cfg_io_ws(cfg_io_ws),
    .cfg_prom_narrow(cfg_prom_narrow), .cfg_prom_prot(cfg_prom_prot),
    .cfg_ram_prot(cfg_ram_prot), .cfg_cb_top(cfg_cb_top), .cfg_cb_low(cfg_cb_low),
    .mem_addr(mem_addr), .mem_data(mem_data), .mem_cb(mem_cb), .mem_oe_n(mem_oe_n),
    .mem_read(mem_read), .mem_we_n(mem_we_n), .prom_cs_n(prom_cs_n),
    .ram_cs_n(ram_cs_n), .ram_oe_n(ram_oe_n), .ram_wen_n(ram_wen_n),
    .io_cs_n(io_cs_n), .io_rdy_n(io_rdy_n)
  );

  task automatic cmp(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic chk_idle(input string rq);
    cmp({rq, " prom_cs_n"}, 64'(prom_cs_n), 64'(2'b11));
    cmp({rq, " ram_cs_n"},  64'(ram_cs_n),  64'({NBANK{1'b1}}));
    cmp({rq, " ram_oe_n"},  64'(ram_oe_n),  64'({NBANK{1'b1}}));
    cmp({rq, " ram_wen_n"}, 64'(ram_wen_n), 64'(4'hf));
    cmp({rq, " io_cs_n"},   64'(io_cs_n),   64'(1'b1));
    cmp({rq, " strobes"},   64'({mem_oe_n, mem_read, mem_we_n}), 64'(3'b101));
    cmp({rq, " data bus"},  64'(mem_data),  64'(32'hzzzz_zzzz));
    cmp({rq, " cb bus"},    64'(mem_cb),    64'(8'hzz));
    cmp({rq, " addr held"}, 64'(mem_addr),  64'(addr_hold));
  endtask

  // Reference model for one access, driven and checked at falling edges.
  task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] wd,
                        input logic [3:0] be, input int extra, input string rq);
    int ar, bank, ws, n;
    bit hi, narrow, prot;
    logic [1:0] e_prom;
    logic [NBANK-1:0] e_ram, e_roe;
    logic [3:0] e_wen;
    logic [31:0] e_data, e_rd;
    logic [7:0] e_cb;
    ar = 0; bank = 0; ws = 0; hi = 0; narrow = 0; prot = 0;
    if (a[31:29] == 3'b000) begin
      ar = 1; hi = a[28]; ws = int'(cfg_prom_ws); narrow = cfg_prom_narrow; prot = cfg_prom_prot;
    end else if (a[31:28] == 4'h2) begin
      ar = 3; ws = int'(cfg_io_ws);
    end else if (a[31:28] == 4'h4 && int'(a[22:20]) < NBANK) begin
      ar = 2; bank = int'(a[22:20]); ws = int'(cfg_ram_ws); prot = cfg_ram_prot;
    end
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd; req_be = be;
    @(negedge clk);
    req_valid = 1'b0;
    if (ar == 0) begin
      cmp({rq, " err rsp_valid"}, 64'(rsp_valid), 64'(1'b1));
      cmp({rq, " err rsp_err"},   64'(rsp_err),   64'(1'b1));
      chk_idle(rq);
      @(negedge clk);
      cmp({rq, " err pulse end"}, 64'(rsp_valid), 64'(1'b0));
      return;
    end
    n = 2 + ws + ((ar == 3) ? extra : 0);
    e_prom = (ar != 1) ? 2'b11 : (hi ? 2'b01 : 2'b10);
    e_ram = '1;
    if (ar == 2) e_ram[bank] = 1'b0;
    e_roe  = wr ? '1 : e_ram;
    e_wen  = !wr ? 4'hf : (narrow ? 4'b1110 : ~be);
    e_data = wr ? (narrow ? {wd[7:0], 24'h0} : wd) : pat(a[27:0]);
    e_cb   = (wr && prot) ? {cfg_cb_top, cfg_cb_low} : 8'hzz;
    for (int c = 1; c <= n; c++) begin
      cmp({rq, " prom_cs_n"}, 64'(prom_cs_n), 64'(e_prom));
      cmp({rq, " ram_cs_n"},  64'(ram_cs_n),  64'(e_ram));
      cmp({rq, " ram_oe_n"},  64'(ram_oe_n),  64'(e_roe));
      cmp({rq, " ram_wen_n"}, 64'(ram_wen_n), 64'(e_wen));
      cmp({rq, " io_cs_n"},   64'(io_cs_n),   64'(ar != 3));
      cmp({rq, " strobes"},   64'({mem_oe_n, mem_read, mem_we_n}), 64'({wr, !wr, !wr}));
      cmp({rq, " data bus"},  64'(mem_data),  64'(e_data));
      cmp({rq, " cb bus"},    64'(mem_cb),    64'(e_cb));
      cmp({rq, " addr"},      64'(mem_addr),  64'(a[27:0]));
      cmp({rq, " busy"},      64'({req_ready, rsp_valid}), 64'(2'b00));
      if (ar == 3) io_rdy_n = (c >= 2 + ws + extra) ? 1'b0 : 1'b1;
      @(negedge clk);
    end
    io_rdy_n = 1'b1;
    addr_hold = a[27:0];
    cmp({rq, " rsp_valid"}, 64'(rsp_valid), 64'(1'b1));
    cmp({rq, " rsp_err"},   64'(rsp_err),   64'(1'b0));
    if (!wr) begin
      e_rd = narrow ? {24'h0, pat(a[27:0])[31:24]} : pat(a[27:0]);
      cmp({rq, " rdata"}, 64'(rsp_rdata), 64'(e_rd));
    end
    chk_idle(rq);
    @(negedge clk);
    cmp({rq, " pulse end"}, 64'(rsp_valid), 64'(1'b0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk_idle("R1 in reset");
    rst = 1'b0;
    @(negedge clk);
    chk_idle("R1 after reset");
    cmp("R1 req_ready", 64'(req_ready), 64'(1'b1));

    access(1'b0, 32'h0000_0100, '0, 4'hf, 0, "R2 R3 R5 prom low read");
    access(1'b0, 32'h1000_0208, '0, 4'hf, 0, "R2 R5 prom high read");
    access(1'b1, 32'h4000_0040, 32'hdead_beef, 4'hf, 0, "R6 R8 ram bank0 write");
    access(1'b1, 32'h4030_0080, 32'h1234_5678, 4'b0101, 0, "R6 R8 ram bank3 lanes");
    access(1'b0, 32'h4040_0010, '0, 4'hf, 0, "R2 R5 ram bank4 read");
    access(1'b0, 32'h4050_0000, '0, 4'hf, 0, "R10 ram bank5 unmapped");
    access(1'b1, 32'h8000_0000, 32'h1, 4'hf, 0, "R10 hole write");
    access(1'b1, 32'h2000_0400, 32'hcafe_f00d, 4'hf, 0, "R4 R8 io write ready early");
    cfg_io_ws = 4'd0;
    access(1'b0, 32'h2000_0404, '0, 4'hf, 3, "R4 io read ready late");
    cfg_io_ws = 4'd1;
    access(1'b1, 32'h2000_0408, 32'h0bad_c0de, 4'b0011, 5, "R4 R6 io write slow");
    cfg_prom_narrow = 1'b1; cfg_prom_prot = 1'b1; cfg_prom_ws = 4'd0;
    access(1'b1, 32'h0000_0013, 32'hffff_ffa5, 4'hf, 0, "R7 R8 prom narrow write");
    access(1'b0, 32'h1000_0021, '0, 4'hf, 0, "R7 prom narrow read");
    cfg_ram_ws = 4'd15; cfg_ram_prot = 1'b0; cfg_cb_top = 1'b0; cfg_cb_low = 7'h55;
    access(1'b1, 32'h4010_0100, 32'h0f0f_f0f0, 4'b1000, 0, "R3 R8 ram max wait unprotected");
    access(1'b0, 32'h4020_0300, '0, 4'hf, 0, "R3 ram max wait read");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk_idle("R9 idle hold");
    end
    access(1'b0, 32'hf000_0000, '0, 4'hf, 0, "R10 top unmapped");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule